// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host processor read and write the on-chip program and data memories without involving the core. The host uses one 16-bit bus for both addresses and data, plus four asynchronous controls: a select, an address-latch strobe, a read strobe and a write strobe. The port returns an acknowledge so the host knows when it may move to the next phase. The host first latches a start address together with a flag that picks program or data memory. Each later read or write moves one word and steps the address, so a block transfer needs only its start address.

All host controls pass through a synchroniser into the core clock domain. Each word then takes exactly one memory cycle, which the core's arbiter grants. Program words are 24 bits wide and cross the 16-bit bus in two transfers. The top of data memory holds the control registers, and the host cannot reach them. When the device boots from the host, the core stays held until a complete word has been written to program location 0.

Top module: `host_mem_port`

## Requirements
- R1: While reset is held, and after it, `h_ack` is 1, `mem_req` is 0 and `h_ad_oe` is 0 until the host acts. At that point `core_hold` equals `boot_mode`.
- R2: An address is latched when `h_ale` falls while the port is selected, or when select is removed while `h_ale` is high. Bus bits [13:0] give the word address and bit 14 is the memory flag (1 = program memory, 0 = data memory).
- R3: A data-memory write (select and `h_wr_n` low) issues exactly one memory write. The write goes to the current address, with `mem_wdata` = {8'h00, bus}.
- R4: A data-memory read issues one memory read. The result then appears as `mem_rdata[15:0]` on `h_ad_out`, with `h_ad_oe` high, once `h_ack` has returned high and while the read strobe is held.
- R5: After every completed data-memory word, and after every completed program-memory word pair, the address steps by one and wraps from 14'h3FFF to 0.
- R6: A program-memory write takes two transfers. The first carries bits [23:8] and starts no memory cycle. The second carries bits [7:0] in bus bits [7:0] and issues one 24-bit write.
- R7: A program-memory read takes two transfers. The first issues one memory read and returns bits [23:8]. The second returns {8'h00, bits [7:0]} and starts no memory cycle.
- R8: `h_ack` drops for at least one cycle after each read or write is detected. It stays low while the memory cycle is pending and rises when the port can accept the next phase.
- R9: While `mem_req` is high and `mem_gnt` is low, the request, address, direction and write data stay unchanged.
- R10: A data-memory address at or above CTRL_BASE (default 14'h3FE0) is refused. A write there makes no memory cycle, a read there returns 0, and the address still steps.
- R11: `core_hold` falls only when a complete program word is written to location 0. Once released it stays low until reset.
- R12: Latching a new address drops any half-finished program word, so the next program transfer is treated as an upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_mode | input | 1 | Device boots through this port |
| h_sel_n | input | 1 | Host select, active low |
| h_ale | input | 1 | Host address-latch strobe, active high |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_ad_in | input | 16 | Multiplexed address/data from the host |
| h_ad_out | output | 16 | Read data towards the host |
| h_ad_oe | output | 1 | Drive enable for `h_ad_out` |
| h_ack | output | 1 | Ready for the next phase |
| mem_req | output | 1 | Memory cycle request to the arbiter |
| mem_we | output | 1 | Requested cycle is a write |
| mem_sel_pm | output | 1 | 1 = program memory, 0 = data memory |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Read data, valid the cycle after the grant |
| mem_gnt | input | 1 | Arbiter grant for the pending request |
| core_hold | output | 1 | Keeps the core from starting |

## Verification
Two things can land in the same cycle. One is the grant of the program-memory write to location 0, which must release `core_hold` in that cycle, while the address counter steps on the same edge. The other is a withheld grant, where the host keeps its strobe low while the arbiter stalls the request. The bench provokes the first by finishing a program word pair at address 0 under random grants, and the second by holding `mem_gnt` low for several cycles in the middle of a write. Each granted memory cycle is compared on the clock edge it happens against a queue of operations the reference model expects. The hold output and `h_ack` are judged at the host's phase boundaries.

// File: rtl/hap_pkg.sv
package hap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DEC   = 3'd1,
    ST_REQ   = 3'd2,
    ST_RWAIT = 3'd3,
    ST_HOLD  = 3'd4
  } hap_state_t;
endpackage

// File: rtl/hap_sync.sv
module hap_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hap_addr.sv
module hap_addr #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_ev,
  input  logic [ADDR_W:0]   latch_bus,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              cur_pm,
  output logic              half,
  output logic              addr_step
);
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  // the address moves after a data word, or after the second half of a program word
  assign addr_step = xfer_done && !latch_ev && (!cur_pm || half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_pm   <= 1'b0;
      half     <= 1'b0;
    end else if (latch_ev) begin
      cur_addr <= latch_bus[ADDR_W-1:0];
      cur_pm   <= latch_bus[ADDR_W];
      half     <= 1'b0;
    end else if (xfer_done) begin
      if (cur_pm) half <= !half;
      if (addr_step) cur_addr <= step_addr(cur_addr);
    end
  end

  assert_half_cleared_R12: assert property (@(posedge clk) disable iff (!rst_n)
    latch_ev |=> !half);
endmodule

// File: rtl/hap_fsm.sv
module hap_fsm
  import hap_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int BUS_W     = 16,
  parameter int PM_W      = 24,
  parameter int CTRL_BASE = 'h3FE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_on,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              cur_pm,
  input  logic              half,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic              mem_gnt,
  input  logic [PM_W-1:0]   mem_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_sel_pm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PM_W-1:0]   mem_wdata,
  output logic [BUS_W-1:0]  rd_data,
  output logic              op_rd,
  output hap_state_t        state,
  output logic              xfer_done
);
  localparam int LO_W = PM_W - BUS_W;
  localparam logic [ADDR_W-1:0] CTRL_LIM = ADDR_W'(CTRL_BASE);

  function automatic logic refused(input logic pm, input logic [ADDR_W-1:0] a);
    return !pm && (a >= CTRL_LIM);
  endfunction

  function automatic logic [PM_W-1:0] join_pm(input logic [BUS_W-1:0] hi, input logic [LO_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic [BUS_W-1:0] hi_q;
  logic [LO_W-1:0]  lo_q;
  logic             dec_mem;

  // does the decoded transfer need a memory cycle
  always_comb begin
    if (cur_pm) dec_mem = is_wr ? half : !half;
    else        dec_mem = !refused(cur_pm, cur_addr);
  end

  assign mem_req    = (state == ST_REQ);
  assign mem_addr   = cur_addr;
  assign mem_sel_pm = cur_pm;
  assign xfer_done  = (state == ST_DEC && !dec_mem) ||
                      (state == ST_REQ && mem_gnt && mem_we) ||
                      (state == ST_RWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      rd_data   <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      op_rd     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (acc_on) state <= ST_DEC;
        ST_DEC: begin
          op_rd <= !is_wr;
          if (is_wr) begin
            mem_we <= 1'b1;
            if (cur_pm && !half) hi_q <= bus_in;
            else if (cur_pm)     mem_wdata <= join_pm(hi_q, bus_in[LO_W-1:0]);
            else                 mem_wdata <= {{LO_W{1'b0}}, bus_in};
          end else begin
            mem_we <= 1'b0;
            if (cur_pm && half) rd_data <= {{(BUS_W-LO_W){1'b0}}, lo_q};
            else if (!dec_mem)  rd_data <= '0;
          end
          state <= dec_mem ? ST_REQ : ST_HOLD;
        end
        ST_REQ: if (mem_gnt) state <= mem_we ? ST_HOLD : ST_RWAIT;
        ST_RWAIT: begin
          if (cur_pm) begin
            rd_data <= mem_rdata[PM_W-1:LO_W];
            lo_q    <= mem_rdata[LO_W-1:0];
          end else begin
            rd_data <= mem_rdata[BUS_W-1:0];
          end
          state <= ST_HOLD;
        end
        ST_HOLD: if (!acc_on) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) &&
                               $stable(mem_wdata) && $stable(mem_sel_pm)));

  assert_ctrl_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_sel_pm || mem_addr < CTRL_LIM));

  assert_pm_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_sel_pm) |-> half);
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
  import hap_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int BUS_W       = 16,
  parameter int PM_W        = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CTRL_BASE   = 'h3FE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_mode,
  input  logic              h_sel_n,
  input  logic              h_ale,
  input  logic              h_rd_n,
  input  logic              h_wr_n,
  input  logic [BUS_W-1:0]  h_ad_in,
  output logic [BUS_W-1:0]  h_ad_out,
  output logic              h_ad_oe,
  output logic              h_ack,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_sel_pm,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PM_W-1:0]   mem_wdata,
  input  logic [PM_W-1:0]   mem_rdata,
  input  logic              mem_gnt,
  output logic              core_hold
);
  localparam int NCTL = 4;

  logic [NCTL-1:0]   raw_ctl, syn_ctl;
  logic              s_sel, s_rd, s_wr, s_ale;
  logic              p_sel, p_ale;
  logic              latch_ev, acc_on;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_pm, half, addr_step, xfer_done, op_rd;
  logic              boot_done, boot_wr_ev;
  hap_state_t        state;

  assign raw_ctl = {h_ale, ~h_wr_n, ~h_rd_n, ~h_sel_n};

  hap_sync #(.W(NCTL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_ctl), .q(syn_ctl)
  );

  assign s_sel = syn_ctl[0];
  assign s_rd  = syn_ctl[1];
  assign s_wr  = syn_ctl[2];
  assign s_ale = syn_ctl[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_sel <= 1'b0;
      p_ale <= 1'b0;
    end else begin
      p_sel <= s_sel;
      p_ale <= s_ale;
    end
  end

  assign latch_ev = (p_ale && !s_ale && s_sel) || (p_sel && !s_sel && s_ale);
  assign acc_on   = s_sel && (s_rd || s_wr);

  hap_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .latch_ev(latch_ev),
    .latch_bus(h_ad_in[ADDR_W:0]), .xfer_done(xfer_done),
    .cur_addr(cur_addr), .cur_pm(cur_pm), .half(half), .addr_step(addr_step)
  );

  hap_fsm #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .PM_W(PM_W), .CTRL_BASE(CTRL_BASE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .acc_on(acc_on), .is_wr(s_wr),
    .cur_addr(cur_addr), .cur_pm(cur_pm), .half(half), .bus_in(h_ad_in),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_sel_pm(mem_sel_pm),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_data(h_ad_out),
    .op_rd(op_rd), .state(state), .xfer_done(xfer_done)
  );

  // boot release event: granted program write at word 0
  assign boot_wr_ev = mem_req && mem_gnt && mem_we && mem_sel_pm && (mem_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          boot_done <= 1'b0;
    else if (boot_wr_ev) boot_done <= 1'b1;
  end

  assign core_hold = boot_mode && !boot_done;
  assign h_ack     = (state == ST_IDLE) || (state == ST_HOLD);
  assign h_ad_oe   = (state == ST_HOLD) && op_rd && s_rd;

  assert_ack_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !h_ack);

  assert_oe_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    h_ad_oe |-> h_ack);

  assert_hold_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_hold) && boot_mode) |-> $past(mem_req && mem_gnt && mem_we && mem_sel_pm && mem_addr == '0));

  assert_hold_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!core_hold && boot_mode) && boot_mode) |-> !core_hold);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_step |=> (mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: tb/sim_host_mem_port.sv
`timescale 1ns/1ps
module sim_host_mem_port;
  localparam logic [13:0] CTRL_LIM = 14'h3FE0;

  typedef struct packed {
    logic        pm;
    logic        we;
    logic [13:0] addr;
    logic [23:0] data;
  } op_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_mode = 1'b1;
  logic        h_sel_n = 1'b1, h_ale = 1'b0, h_rd_n = 1'b1, h_wr_n = 1'b1;
  logic [15:0] h_ad_in = '0;
  logic [15:0] h_ad_out;
  logic        h_ad_oe, h_ack, mem_req, mem_we, mem_sel_pm, core_hold;
  logic [13:0] mem_addr;
  logic [23:0] mem_wdata;
  logic [23:0] mem_rdata = '0;
  logic        mem_gnt = 1'b0;

  int checks = 0;
  int fails  = 0;
  int gnt_mode = 1;

  op_t exp_q[$];
  logic [23:0] env_pm [int];
  logic [23:0] env_dm [int];
  logic [23:0] ref_pm [int];
  logic [23:0] ref_dm [int];

  logic [13:0] m_addr = '0;
  logic        m_pm = 1'b0, m_half = 1'b0, m_boot = 1'b0;
  logic [15:0] m_hi = '0;
  logic [7:0]  m_lo = '0;

  always #10 clk = ~clk;

  host_mem_port u0 (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
    .h_sel_n(h_sel_n), .h_ale(h_ale), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n),
    .h_ad_in(h_ad_in), .h_ad_out(h_ad_out), .h_ad_oe(h_ad_oe), .h_ack(h_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_sel_pm(mem_sel_pm),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_gnt(mem_gnt), .core_hold(core_hold)
  );

  function automatic logic [23:0] pat(input logic pm, input logic [13:0] a);
    return pm ? {~a[7:0], 2'b01, a} : {8'hEE, (16'h1234 ^ {2'b10, a})};
  endfunction

  function automatic logic [23:0] ref_word(input logic pm, input logic [13:0] a);
    if (pm) return ref_pm.exists(int'(a)) ? ref_pm[int'(a)] : pat(1'b1, a);
    return ref_dm.exists(int'(a)) ? ref_dm[int'(a)] : pat(1'b0, a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // grant pattern, changed away from the sampling edge
  always @(negedge clk) begin
    case (gnt_mode)
      0: mem_gnt <= 1'b0;
      1: mem_gnt <= 1'b1;
      default: mem_gnt <= 1'($urandom % 2);
    endcase
  end

  // memory responder and per-clock comparison of granted cycles
  always @(posedge clk) begin
    if (rst_n && mem_req && mem_gnt) begin
      op_t e;
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3/R6/R10 unexpected memory cycle pm=%b we=%b addr=%h data=%h expected=none",
                 mem_sel_pm, mem_we, mem_addr, mem_wdata);
      end else begin
        e = exp_q.pop_front();
        chk("R3/R6/R7 cycle kind", {30'd0, mem_sel_pm, mem_we}, {30'd0, e.pm, e.we});
        chk("R2/R5 cycle address", {18'd0, mem_addr}, {18'd0, e.addr});
        if (e.we) chk("R3/R6 write data", {8'd0, mem_wdata}, {8'd0, e.data});
      end
      if (mem_we) begin
        if (mem_sel_pm) env_pm[int'(mem_addr)] = mem_wdata;
        else            env_dm[int'(mem_addr)] = mem_wdata;
      end else begin
        if (mem_sel_pm) mem_rdata <= env_pm.exists(int'(mem_addr)) ? env_pm[int'(mem_addr)] : pat(1'b1, mem_addr);
        else            mem_rdata <= env_dm.exists(int'(mem_addr)) ? env_dm[int'(mem_addr)] : pat(1'b0, mem_addr);
      end
    end
  end

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch_ale(input logic pm, input logic [13:0] a);
    @(negedge clk);
    h_ad_in = {1'b0, pm, a}; h_sel_n = 1'b0; h_ale = 1'b1;
    gap(4); h_ale = 1'b0;
    gap(5); h_sel_n = 1'b1;
    gap(5);
    m_addr = a; m_pm = pm; m_half = 1'b0;
  endtask

  task automatic latch_sel(input logic pm, input logic [13:0] a);
    @(negedge clk);
    h_ad_in = {1'b0, pm, a}; h_sel_n = 1'b0; h_ale = 1'b1;
    gap(4); h_sel_n = 1'b1;
    gap(5); h_ale = 1'b0;
    gap(5);
    m_addr = a; m_pm = pm; m_half = 1'b0;
  endtask

  task automatic wait_ack(input logic lvl);
    for (int i = 0; i < 2000 && h_ack !== lvl; i++) @(negedge clk);
  endtask

  task automatic host_write(input logic [15:0] d, input bit stall);
    logic step;
    step = 1'b1;
    if (m_pm) begin
      if (!m_half) begin
        m_hi = d; m_half = 1'b1; step = 1'b0;
      end else begin
        exp_q.push_back('{1'b1, 1'b1, m_addr, {m_hi, d[7:0]}});
        ref_pm[int'(m_addr)] = {m_hi, d[7:0]};
        m_half = 1'b0;
      end
    end else if (m_addr < CTRL_LIM) begin
      exp_q.push_back('{1'b0, 1'b1, m_addr, {8'h00, d}});
      ref_dm[int'(m_addr)] = {8'h00, d};
    end
    @(negedge clk);
    if (stall) gnt_mode = 0;
    h_ad_in = d; h_sel_n = 1'b0; h_wr_n = 1'b0;
    wait_ack(1'b0);
    if (stall) begin
      gap(6);
      chk("R9 request held while grant withheld", {31'd0, mem_req}, 32'd1);
      chk("R8 ack low while pending", {31'd0, h_ack}, 32'd0);
      gnt_mode = 1;
    end
    wait_ack(1'b1);
    chk("R8 ack back high", {31'd0, h_ack}, 32'd1);
    h_wr_n = 1'b1; h_sel_n = 1'b1;
    gap(6);
    if (step) begin
      if (m_pm && m_addr == 14'd0) m_boot = 1'b1;
      m_addr = m_addr + 14'd1;
    end
  endtask

  task automatic host_read(input string req);
    logic [15:0] e;
    logic [23:0] w;
    logic step;
    step = 1'b1;
    w = ref_word(m_pm, m_addr);
    if (m_pm) begin
      if (!m_half) begin
        exp_q.push_back('{1'b1, 1'b0, m_addr, 24'h0});
        e = w[23:8]; m_lo = w[7:0]; m_half = 1'b1; step = 1'b0;
      end else begin
        e = {8'h00, m_lo}; m_half = 1'b0;
      end
    end else if (m_addr < CTRL_LIM) begin
      exp_q.push_back('{1'b0, 1'b0, m_addr, 24'h0});
      e = w[15:0];
    end else begin
      e = 16'h0000;
    end
    @(negedge clk);
    h_sel_n = 1'b0; h_rd_n = 1'b0;
    wait_ack(1'b0);
    wait_ack(1'b1);
    gap(1);
    chk({req, " read drive enable"}, {31'd0, h_ad_oe}, 32'd1);
    chk({req, " read data"}, {16'd0, h_ad_out}, {16'd0, e});
    h_rd_n = 1'b1; h_sel_n = 1'b1;
    gap(6);
    if (step) m_addr = m_addr + 14'd1;
  endtask

  task automatic check_hold(input string req);
    chk(req, {31'd0, core_hold}, {31'd0, boot_mode && !m_boot});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    gap(3);
    // R1 reset values
    chk("R1 ack in reset", {31'd0, h_ack}, 32'd1);
    chk("R1 no request in reset", {31'd0, mem_req}, 32'd0);
    chk("R1 bus not driven", {31'd0, h_ad_oe}, 32'd0);
    check_hold("R1 hold follows boot_mode");
    rst_n = 1'b1;
    gap(3);
    chk("R1 ack after reset", {31'd0, h_ack}, 32'd1);

    // R2 R3 R5 data memory writes from a latched start
    latch_ale(1'b0, 14'h0100);
    host_write(16'hA001, 1'b0);
    host_write(16'hB002, 1'b0);
    host_write(16'hC003, 1'b1);   // R9 stalled grant
    // R4 reading back plus unwritten neighbour
    latch_ale(1'b0, 14'h0100);
    for (int i = 0; i < 4; i++) host_read("R4");

    // R6 program word write away from location 0, R11 hold kept
    latch_ale(1'b1, 14'h0005);
    host_write(16'h1357, 1'b0);
    check_hold("R6 no memory cycle on upper half, hold kept");
    host_write(16'h009A, 1'b0);
    check_hold("R11 hold kept after write to location 5");
    // R7 program read in two halves
    latch_ale(1'b1, 14'h0005);
    host_read("R7 upper");
    host_read("R7 lower");
    host_read("R7 next upper");
    host_read("R7 next lower");

    // R12 aborted pair
    latch_ale(1'b1, 14'h0008);
    host_write(16'hDEAD, 1'b0);
    latch_ale(1'b1, 14'h0008);
    host_write(16'h4242, 1'b0);
    host_write(16'h0077, 1'b0);
    latch_ale(1'b1, 14'h0008);
    host_read("R12 upper after relatch");
    host_read("R12 lower after relatch");

    // R11 boot release with random grants
    gnt_mode = 2;
    latch_ale(1'b1, 14'h0000);
    host_write(16'h0BAD, 1'b0);
    check_hold("R11 hold kept after first half at location 0");
    host_write(16'h00C0, 1'b0);
    check_hold("R11 hold released after word at location 0");

    // R10 control region at the top of data memory
    latch_ale(1'b0, 14'h3FDF);
    host_write(16'h5555, 1'b0);
    host_write(16'h6666, 1'b0);   // refused
    host_write(16'h7777, 1'b0);   // refused, address 3FE1
    latch_ale(1'b0, 14'h3FDF);
    host_read("R10 last plain word");
    host_read("R10 refused read");
    host_read("R10 refused read stepped");

    // R5 wrap of the address in program memory
    latch_sel(1'b1, 14'h3FFF);    // R2 latch by select edge
    host_write(16'h2468, 1'b0);
    host_write(16'h0011, 1'b0);
    host_read("R5 wrapped to 0 upper");
    host_read("R5 wrapped to 0 lower");

    // R2 select-edge latch on data memory
    latch_sel(1'b0, 14'h0200);
    host_write(16'h8181, 1'b0);
    host_read("R2 R5 stepped past 0200");
    latch_ale(1'b0, 14'h0200);
    host_read("R2 select latched word");
    check_hold("R11 hold stays released");

    gnt_mode = 1;
    gap(5);
    chk("R3 all expected cycles seen", exp_q.size(), 32'd0);
    chk("R1 idle ack at end", {31'd0, h_ack}, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule